// File: doc/BRIEF.md
# Program Memory Byte Loader

This block sits between a byte-wide register bus and the 64-word, 16-bit program store of one waveform-sequencer channel. Software reaches the store through a single data port whose bus address never changes. Each instruction word is sent as two bytes, high byte first. An internal word pointer moves forward by one word each time a word completes, so a stream of bus writes to the same port fills the store one word after another. Reads from the port return stored words in the same high-then-low byte order and move the same pointer.

Loading is only allowed while the channel is held in reset, meaning its enable input is low. When a software access goes to any other register, the pointer goes back to word 0 and the byte phase goes back to "high". Software rewinds the loader this way before it streams in a new program. The pointer wraps from the last word back to word 0, so an over-long program overwrites the start of the store. A second, combinational read port gives the execution engine its fetch path into the same storage.

Top module: `prog_byte_port`

## Requirements
- R1: After synchronous reset, `rd_valid` and `mem_we` are 0, the pointer is at word 0 and the byte phase is "high".
- R2: With `chan_en` at 0, the first byte written is held as the high byte. The second byte completes the word. In the same cycle as that second byte, `mem_we` is 1 and `mem_wdata` = {first byte, second byte}, so bits 15:8 come from the first byte. No store write happens on a high byte.
- R3: Each completed word goes to the pointer's word, and the pointer then advances by one. Consecutive words therefore land at consecutive addresses, starting at 0.
- R4: A word completed at address DEPTH-1 (63 by default) is followed by a pointer of 0, so the next word overwrites word 0.
- R5: An `other_stb` cycle sets the pointer to word 0 and the byte phase to "high". A pending high byte is discarded.
- R6: A write strobe while `chan_en` is 1 has no effect. It causes no store write, it does not move the pointer, and it does not change the byte phase.
- R7: A read strobe returns, one cycle later with `rd_valid` = 1, the high byte of the word at the pointer and then, on the next read strobe, the low byte. After the low byte the pointer advances. Reads work whatever `chan_en` is.
- R8: `fetch_word` always shows the stored word at `fetch_addr`.
- R9: Strobe priority is fixed. `other_stb` beats `wr_stb`, and `wr_stb` beats `rd_stb`. A losing strobe has no effect, and that includes a write that loses because the channel is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Byte write to the program data port |
| wr_data | input | 8 | Byte written |
| rd_stb | input | 1 | Byte read from the program data port |
| rd_data | output | 8 | Byte returned, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_stb |
| other_stb | input | 1 | Bus access to any other register |
| chan_en | input | 1 | Channel enable; loading only while 0 |
| fetch_addr | input | 6 | Execution fetch address |
| fetch_word | output | 16 | Stored word at fetch_addr |
| mem_we | output | 1 | Store write strobe |
| mem_addr | output | 6 | Store write address |
| mem_wdata | output | 16 | Store write word |

## Verification
The bench goes after four hazards:

- **Byte order.** Reversed byte order would show up as swapped halves in the fetched and read-back words.
- **Mid-word rewind.** A rewind that leaves the byte phase alone would make the next word use a stale high byte. The bench checks this with `other_stb` sent between the high and low bytes.
- **Writes while enabled.** If such writes advanced the pointer or flipped the phase, the following legal word would be misaligned or land at the wrong address.
- **Pointer wrap.** The bench loads 65 words to make the pointer wrap. A design without the wrap would leave word 0 untouched.

Collisions of simultaneous strobes check the fixed priority. A design that got the priority wrong would store a byte that should have been dropped, or give a read response that should not exist.

// File: rtl/prog_port_pkg.sv
package prog_port_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic {
        PH_HI = 1'b0,
        PH_LO = 1'b1
    } byte_phase_e;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_REWIND = 2'd1,
        OP_WRITE  = 2'd2,
        OP_READ   = 2'd3
    } port_op_e;

    // Byte of a word that belongs to the given phase.
    function automatic logic [BYTE_W-1:0] pick_byte(
        input logic [WORD_W-1:0] w,
        input byte_phase_e       ph
    );
        return (ph == PH_HI) ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/prog_port_decode.sv
module prog_port_decode
    import prog_port_pkg::*;
(
    input  logic     wr_stb,
    input  logic     rd_stb,
    input  logic     other_stb,
    input  logic     chan_en,
    output port_op_e op
);

    // Fixed priority: rewind, then write (dropped while enabled), then read.
    always_comb begin
        if (other_stb) begin
            op = OP_REWIND;
        end else if (wr_stb) begin
            op = chan_en ? OP_NONE : OP_WRITE;
        end else if (rd_stb) begin
            op = OP_READ;
        end else begin
            op = OP_NONE;
        end
    end

endmodule

// File: rtl/prog_ptr_ctrl.sv
module prog_ptr_ctrl
    import prog_port_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  port_op_e          op,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [AW-1:0]     ptr,
    output byte_phase_e       phase,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0]     ptr_q;
    byte_phase_e       phase_q;
    logic [BYTE_W-1:0] hi_q;
    logic [AW-1:0]     ptr_inc;

    assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + AW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            phase_q <= PH_HI;
            hi_q    <= '0;
        end else begin
            case (op)
                OP_REWIND: begin
                    ptr_q   <= '0;
                    phase_q <= PH_HI;
                end
                OP_WRITE: begin
                    if (phase_q == PH_HI) begin
                        hi_q    <= wr_data;
                        phase_q <= PH_LO;
                    end else begin
                        phase_q <= PH_HI;
                        ptr_q   <= ptr_inc;
                    end
                end
                OP_READ: begin
                    if (phase_q == PH_HI) begin
                        phase_q <= PH_LO;
                    end else begin
                        phase_q <= PH_HI;
                        ptr_q   <= ptr_inc;
                    end
                end
                default: ;
            endcase
        end
    end

    assign mem_we    = (op == OP_WRITE) && (phase_q == PH_LO);
    assign mem_addr  = ptr_q;
    assign mem_wdata = {hi_q, wr_data};
    assign ptr       = ptr_q;
    assign phase     = phase_q;

endmodule

// File: rtl/prog_store.sv
module prog_store
    import prog_port_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    output logic [WORD_W-1:0] rdata_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [WORD_W-1:0] rdata_b
);

    logic [WORD_W-1:0] words [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(i))) begin
                word_q <= wdata;
            end
        end
        assign words[i] = word_q;
    end

    assign rdata_a = words[raddr_a];
    assign rdata_b = words[raddr_b];

endmodule

// File: rtl/prog_byte_port.sv
module prog_byte_port
    import prog_port_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_stb,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              other_stb,
    input  logic              chan_en,
    input  logic [AW-1:0]     fetch_addr,
    output logic [WORD_W-1:0] fetch_word,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata
);

    port_op_e          op;
    logic [AW-1:0]     ptr;
    byte_phase_e       phase;
    logic [WORD_W-1:0] cur_word;

    prog_port_decode u_decode (
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb),
        .other_stb (other_stb),
        .chan_en   (chan_en),
        .op        (op)
    );

    prog_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .wr_data   (wr_data),
        .ptr       (ptr),
        .phase     (phase),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    prog_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_addr),
        .wdata   (mem_wdata),
        .raddr_a (ptr),
        .rdata_a (cur_word),
        .raddr_b (fetch_addr),
        .rdata_b (fetch_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (op == OP_READ);
            if (op == OP_READ) begin
                rd_data <= pick_byte(cur_word, phase);
            end
        end
    end

endmodule

// File: rtl/prog_port_chk.sv
module prog_port_chk
    import prog_port_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_stb,
    input logic          rd_stb,
    input logic          other_stb,
    input logic          chan_en,
    input logic          rd_valid,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] ptr,
    input byte_phase_e   phase
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (ptr == '0) && (phase == PH_HI) && !rd_valid);

    // R2
    write_on_low_only_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (phase == PH_LO) && wr_stb);

    // R2
    high_byte_flips_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !chan_en && !other_stb && phase == PH_HI) |=> (phase == PH_LO));

    // R3
    ptr_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_addr != LAST) |=> (ptr == $past(mem_addr) + AW'(1)));

    // R4
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_addr == LAST) |=> (ptr == '0));

    // R5
    rewind_chk: assert property (@(posedge clk) disable iff (rst)
        other_stb |=> (ptr == '0) && (phase == PH_HI));

    // R6
    enabled_no_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && chan_en) |-> !mem_we);

    // R6
    enabled_state_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && chan_en && !other_stb) |=> $stable(ptr) && $stable(phase));

    // R7
    read_response_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !wr_stb && !other_stb) |=> rd_valid);

    // R9
    no_stray_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_stb || wr_stb || other_stb) |=> !rd_valid);

endmodule

bind prog_byte_port prog_port_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .other_stb (other_stb),
    .chan_en   (chan_en),
    .rd_valid  (rd_valid),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .ptr       (ptr),
    .phase     (phase)
);

// File: tb/prog_byte_port_bench.sv
`timescale 1ns/1ps
module prog_byte_port_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_stb = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        other_stb = 1'b0;
    logic        chan_en = 1'b0;
    logic [5:0]  fetch_addr = '0;
    logic [15:0] fetch_word;
    logic        mem_we;
    logic [5:0]  mem_addr;
    logic [15:0] mem_wdata;

    always #10 clk = ~clk;

    prog_byte_port u_prog_byte_port (
        .clk        (clk),
        .rst        (rst),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .rd_stb     (rd_stb),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .other_stb  (other_stb),
        .chan_en    (chan_en),
        .fetch_addr (fetch_addr),
        .fetch_word (fetch_word),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    typedef struct {
        logic [5:0]  a;
        logic [15:0] d;
        string       tag;
    } wr_item_t;

    typedef struct {
        logic [7:0] b;
        string      tag;
    } rd_item_t;

    wr_item_t exp_wr[$];
    rd_item_t exp_rd[$];

    int n_chk  = 0;
    int n_fail = 0;

    // Reference model built from the requirements
    logic [15:0] m_mem [64];
    logic [5:0]  m_ptr = '0;
    logic        m_lo  = 1'b0;
    logic [7:0]  m_hi  = '0;

    task automatic result(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One bus cycle; the model follows the same priority (R9)
    task automatic step(input logic w, input logic [7:0] d, input logic r, input logic o, input string tag);
        wr_item_t wi;
        rd_item_t ri;
        if (o) begin
            m_ptr = '0;
            m_lo  = 1'b0;
        end else if (w) begin
            if (!chan_en) begin
                if (!m_lo) begin
                    m_hi = d;
                    m_lo = 1'b1;
                end else begin
                    wi.a = m_ptr;
                    wi.d = {m_hi, d};
                    wi.tag = (m_ptr == 6'd63) ? "R4" : tag;
                    exp_wr.push_back(wi);
                    m_mem[m_ptr] = {m_hi, d};
                    m_ptr = m_ptr + 6'd1;
                    m_lo  = 1'b0;
                end
            end
        end else if (r) begin
            ri.b   = m_lo ? m_mem[m_ptr][7:0] : m_mem[m_ptr][15:8];
            ri.tag = "R7";
            exp_rd.push_back(ri);
            if (m_lo) m_ptr = m_ptr + 6'd1;
            m_lo = ~m_lo;
        end
        wr_stb = w; wr_data = d; rd_stb = r; other_stb = o;
        @(posedge clk); #1;
        wr_stb = 1'b0; rd_stb = 1'b0; other_stb = 1'b0;
    endtask

    task automatic put_word(input logic [15:0] v, input string tag);
        step(1'b1, v[15:8], 1'b0, 1'b0, tag);
        step(1'b1, v[7:0],  1'b0, 1'b0, tag);
    endtask

    task automatic check_fetch(input logic [5:0] a, input logic [15:0] e, input string tag);
        fetch_addr = a;
        #1;
        result(fetch_word === e, tag, 32'(fetch_word), 32'(e));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    // Scoreboard monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                if (exp_wr.size() == 0) begin
                    result(1'b0, "R6/R9 unexpected store write", 32'({mem_addr, mem_wdata}), 32'h0);
                end else begin
                    wr_item_t e;
                    e = exp_wr.pop_front();
                    result(mem_addr === e.a && mem_wdata === e.d, e.tag,
                           32'({mem_addr, mem_wdata}), 32'({e.a, e.d}));
                end
            end
            if (rd_valid) begin
                if (exp_rd.size() == 0) begin
                    result(1'b0, "R9 unexpected read data", 32'(rd_data), 32'h0);
                end else begin
                    rd_item_t e;
                    e = exp_rd.pop_front();
                    result(rd_data === e.b, e.tag, 32'(rd_data), 32'(e.b));
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset outputs
        result(rd_valid === 1'b0, "R1 rd_valid", 32'(rd_valid), 32'h0);
        result(mem_we === 1'b0, "R1 mem_we", 32'(mem_we), 32'h0);
        @(posedge clk); #1;

        // R1 R2 R3: first words from address 0, high byte first
        put_word(16'h1234, "R2");
        put_word(16'hABCD, "R3");
        put_word(16'h0F0F, "R3");
        // R8 fetch port
        check_fetch(6'd0, 16'h1234, "R8");
        check_fetch(6'd1, 16'hABCD, "R8");
        check_fetch(6'd2, 16'h0F0F, "R8");

        // R5 then R7 read-back high then low
        step(1'b0, 8'h00, 1'b0, 1'b1, "R5");
        for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b1, 1'b0, "R7");
        idle(2);

        // R7 read while enabled
        chan_en = 1'b1;
        step(1'b0, 8'h00, 1'b1, 1'b0, "R7");
        step(1'b0, 8'h00, 1'b1, 1'b0, "R7");
        chan_en = 1'b0;
        idle(2);

        // R5 mid-word rewind discards the pending high byte
        step(1'b0, 8'h00, 1'b0, 1'b1, "R5");
        step(1'b1, 8'h55, 1'b0, 1'b0, "R5");
        step(1'b0, 8'h00, 1'b0, 1'b1, "R5");
        put_word(16'h7788, "R5");
        check_fetch(6'd0, 16'h7788, "R5");

        // R6: writes while enabled are ignored; pointer and phase held
        chan_en = 1'b1;
        step(1'b1, 8'h99, 1'b0, 1'b0, "R6");
        step(1'b1, 8'hAA, 1'b0, 1'b0, "R6");
        step(1'b1, 8'hBB, 1'b0, 1'b0, "R6");
        chan_en = 1'b0;
        check_fetch(6'd1, 16'hABCD, "R6");
        put_word(16'h1122, "R6");
        check_fetch(6'd1, 16'h1122, "R6");
        check_fetch(6'd2, 16'h0F0F, "R6");

        // R9 rewind beats write; write beats read
        step(1'b1, 8'hDE, 1'b0, 1'b0, "R9");
        step(1'b1, 8'hAD, 1'b0, 1'b1, "R9");
        put_word(16'h0102, "R9");
        check_fetch(6'd0, 16'h0102, "R9");
        step(1'b1, 8'h03, 1'b1, 1'b0, "R9");
        step(1'b1, 8'h04, 1'b1, 1'b0, "R9");
        check_fetch(6'd1, 16'h0304, "R9");
        idle(2);

        // R4: 65 words wrap the pointer onto word 0
        step(1'b0, 8'h00, 1'b0, 1'b1, "R4");
        for (int i = 0; i < 65; i++) begin
            put_word({8'(i) ^ 8'h5A, 8'(i)}, "R3");
        end
        check_fetch(6'd0, {8'd64 ^ 8'h5A, 8'd64}, "R4");
        check_fetch(6'd63, {8'd63 ^ 8'h5A, 8'd63}, "R4");
        check_fetch(6'd1, {8'd1 ^ 8'h5A, 8'd1}, "R4");

        // R7 read after wrap continues at word 1
        for (int i = 0; i < 2; i++) step(1'b0, 8'h00, 1'b1, 1'b0, "R7");
        idle(3);

        result(exp_wr.size() == 0, "R2 pending store writes", 32'(exp_wr.size()), 32'h0);
        result(exp_rd.size() == 0, "R7 pending read bytes", 32'(exp_rd.size()), 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule